// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches virtual-to-physical page mappings in a small, fully associative array. Each entry stores its own page size, given as a log2 byte count. A lookup compares the request against every entry in the same cycle. On a hit it returns the physical address and four attribute bits: writable, user, uncacheable and global. On a miss it raises a miss flag, so that an external table walker can fetch the mapping and present it on the insert port.

Replacement uses a global stamp counter. An insert writes the next stamp into the entry it fills. A lookup does the same when its recency flag is set. When every entry is valid, the entry with the smallest stamp is replaced. Three maintenance commands are provided:
- flush everything;
- flush only the entries whose global bit is clear;
- drop the single entry that a given virtual address hits.

The entry count must be at least one, and a zero count stops elaboration.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid and the stamp counter holds 1. Every lookup misses until an insert completes.
- R2: An entry matches when it is valid and the lookup address equals its tag in all bits at or above its log2 page size. When several entries match, the lowest index is used. hit_o and miss_o are both low unless lk_valid_i is high, and exactly one of them is high when it is.
- R3: On a hit, pa_o is the entry's page base ORed with the lookup address bits below the page size, and the attribute outputs are the entry's bits. On a miss, or with no lookup, pa_o and all attribute outputs are zero.
- R4: An insert stores the virtual tag and the physical base, both with the bits below the page size cleared. It fills the lowest-index invalid entry when one exists.
- R5: When all entries are valid, an insert replaces the entry with the smallest stamp. Equal stamps go to the lowest index.
- R6: An insert, and a lookup that hits with lk_touch_i high, write the counter value into the chosen entry's stamp and then increment the counter. A lookup with lk_touch_i low changes no stamp.
- R7: A stamp taken while the counter is at its all-ones value first clears every stamp to 0. The chosen entry then gets 1, and the counter becomes 2.
- R8: flush_all_i invalidates every entry at the next clock edge.
- R9: flush_local_i invalidates every valid entry whose global bit is 0. Global entries stay valid.
- R10: demap_valid_i invalidates only the lowest-index entry that demap_va_i matches, under the R2 rule. If no entry matches, nothing changes.
- R11: At most one action takes effect per cycle. The priority order is flush_all_i, then flush_local_i, then demap_valid_i, then ins_valid_i, then the recency update. Every lower-priority request in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | ADDR_W | Lookup virtual address |
| lk_touch_i | input | 1 | Refresh the stamp of the entry that hits |
| hit_o | output | 1 | Lookup hit |
| miss_o | output | 1 | Lookup miss; the walker should supply the mapping |
| pa_o | output | ADDR_W | Translated physical address |
| writable_o | output | 1 | Hit entry is writable |
| user_o | output | 1 | Hit entry is user accessible |
| uncache_o | output | 1 | Hit entry is uncacheable |
| global_o | output | 1 | Hit entry is global |
| ins_valid_i | input | 1 | Insert request |
| ins_va_i | input | ADDR_W | Virtual address of the new mapping |
| ins_pa_i | input | ADDR_W | Physical page base of the new mapping |
| ins_lsz_i | input | LOG_W | log2 page size in bytes |
| ins_writable_i | input | 1 | Writable attribute |
| ins_user_i | input | 1 | User attribute |
| ins_uncache_i | input | 1 | Uncacheable attribute |
| ins_global_i | input | 1 | Global attribute |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_local_i | input | 1 | Invalidate all non-global entries |
| demap_valid_i | input | 1 | Demap request |
| demap_va_i | input | ADDR_W | Virtual address to demap |

## Verification
The first set of patterns is directed. Lookups are made at the first and last byte of a page and one byte beyond it, with 4 KiB and 64 KiB pages. These show whether the tag compare and the offset merge use the right boundary. A 2 MiB page placed over a 4 KiB page tells the lowest-index rule apart from a compare on the most specific match, for both lookup and demap.

Fill-then-evict runs use three stamp histories: with and without recency updates, and past a counter wrap. In each case only the entry that should leave misses afterwards.

A long pseudo-random mix then combines inserts, touching and plain lookups, demaps, both flushes and same-cycle collisions. Every output is compared against an arithmetic model of the array.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  typedef struct packed {
    logic wr;
    logic usr;
    logic unc;
    logic glb;
  } pg_attr_t;
endpackage

// File: rtl/xlat_cache_match.sv
module xlat_cache_match #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LOG_W   = 5
) (
  input  logic [ADDR_W-1:0] va_i,
  input  logic [ENTRIES-1:0] vld_i,
  input  logic [ADDR_W-1:0] tag_i [ENTRIES],
  input  logic [LOG_W-1:0]  lsz_i [ENTRIES],
  output logic [ENTRIES-1:0] match_o
);
  function automatic logic [ADDR_W-1:0] page_mask(input logic [LOG_W-1:0] l);
    return ~((ADDR_W'(1) << l) - ADDR_W'(1));
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = vld_i[g] && (((va_i ^ tag_i[g]) & page_mask(lsz_i[g])) == '0);
  end
endmodule

// File: rtl/xlat_cache_first.sv
module xlat_cache_first #(
  parameter int unsigned N    = 8,
  parameter int unsigned IW   = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        found = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/xlat_cache_lru.sv
module xlat_cache_lru #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned SEQ_W   = 32,
  parameter int unsigned IW      = 3
) (
  input  logic [SEQ_W-1:0] stamp_i [ENTRIES],
  output logic [IW-1:0]    idx_o
);
  // strict less-than keeps the first minimum
  always_comb begin
    int best;
    best = 0;
    for (int i = 1; i < ENTRIES; i++) begin
      if (stamp_i[i] < stamp_i[best]) best = i;
    end
    idx_o = IW'(best);
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SEQ_W   = 32,
  localparam int unsigned LOG_W  = $clog2(ADDR_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_va_i,
  input  logic              lk_touch_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic              writable_o,
  output logic              user_o,
  output logic              uncache_o,
  output logic              global_o,
  input  logic              ins_valid_i,
  input  logic [ADDR_W-1:0] ins_va_i,
  input  logic [ADDR_W-1:0] ins_pa_i,
  input  logic [LOG_W-1:0]  ins_lsz_i,
  input  logic              ins_writable_i,
  input  logic              ins_user_i,
  input  logic              ins_uncache_i,
  input  logic              ins_global_i,
  input  logic              flush_all_i,
  input  logic              flush_local_i,
  input  logic              demap_valid_i,
  input  logic [ADDR_W-1:0] demap_va_i
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  if (ENTRIES < 1) begin : g_bad_cfg
    $error("xlat_cache: ENTRIES must be non-zero");
  end

  function automatic logic [ADDR_W-1:0] page_mask(input logic [LOG_W-1:0] l);
    return ~((ADDR_W'(1) << l) - ADDR_W'(1));
  endfunction

  logic [ENTRIES-1:0] vld_q;
  logic [ADDR_W-1:0]  tag_q   [ENTRIES];
  logic [ADDR_W-1:0]  base_q  [ENTRIES];
  logic [LOG_W-1:0]   lsz_q   [ENTRIES];
  pg_attr_t           attr_q  [ENTRIES];
  logic [SEQ_W-1:0]   stamp_q [ENTRIES];
  logic [SEQ_W-1:0]   seq_q;
  logic [ENTRIES-1:0] glb_vec;

  logic [ENTRIES-1:0] lk_raw, dm_raw;
  logic [IDX_W-1:0]   lk_idx, dm_idx, free_idx, lru_idx, vic_idx, st_idx;
  logic               lk_any, dm_any, free_any, do_stamp;
  logic [ADDR_W-1:0]  ins_msk;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_glb
    assign glb_vec[g] = attr_q[g].glb;
  end

  xlat_cache_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_lk_match (
    .va_i(lk_va_i), .vld_i(vld_q), .tag_i(tag_q), .lsz_i(lsz_q), .match_o(lk_raw));
  xlat_cache_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LOG_W(LOG_W)) u_dm_match (
    .va_i(demap_va_i), .vld_i(vld_q), .tag_i(tag_q), .lsz_i(lsz_q), .match_o(dm_raw));

  xlat_cache_first #(.N(ENTRIES), .IW(IDX_W)) u_lk_first (
    .req_i(lk_raw), .idx_o(lk_idx), .any_o(lk_any));
  xlat_cache_first #(.N(ENTRIES), .IW(IDX_W)) u_dm_first (
    .req_i(dm_raw), .idx_o(dm_idx), .any_o(dm_any));
  xlat_cache_first #(.N(ENTRIES), .IW(IDX_W)) u_free_first (
    .req_i(~vld_q), .idx_o(free_idx), .any_o(free_any));

  xlat_cache_lru #(.ENTRIES(ENTRIES), .SEQ_W(SEQ_W), .IW(IDX_W)) u_lru (
    .stamp_i(stamp_q), .idx_o(lru_idx));

  assign vic_idx = free_any ? free_idx : lru_idx;
  assign ins_msk = page_mask(ins_lsz_i);

  // lookup datapath
  assign hit_o  = lk_valid_i & lk_any;
  assign miss_o = lk_valid_i & ~lk_any;
  always_comb begin
    pa_o       = '0;
    writable_o = 1'b0;
    user_o     = 1'b0;
    uncache_o  = 1'b0;
    global_o   = 1'b0;
    if (hit_o) begin
      pa_o       = base_q[lk_idx] | (lk_va_i & ~page_mask(lsz_q[lk_idx]));
      writable_o = attr_q[lk_idx].wr;
      user_o     = attr_q[lk_idx].usr;
      uncache_o  = attr_q[lk_idx].unc;
      global_o   = attr_q[lk_idx].glb;
    end
  end

  // one action per cycle, fixed priority
  always_comb begin
    do_stamp = 1'b0;
    st_idx   = lk_idx;
    if (!flush_all_i && !flush_local_i && !demap_valid_i) begin
      if (ins_valid_i) begin
        do_stamp = 1'b1;
        st_idx   = vic_idx;
      end else if (hit_o && lk_touch_i) begin
        do_stamp = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      seq_q <= SEQ_W'(1);
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]   <= '0;
        base_q[i]  <= '0;
        lsz_q[i]   <= '0;
        attr_q[i]  <= '0;
        stamp_q[i] <= '0;
      end
    end else begin
      if (flush_all_i) begin
        vld_q <= '0;
      end else if (flush_local_i) begin
        vld_q <= vld_q & glb_vec;
      end else if (demap_valid_i) begin
        if (dm_any) vld_q[dm_idx] <= 1'b0;
      end else if (ins_valid_i) begin
        vld_q[vic_idx]  <= 1'b1;
        tag_q[vic_idx]  <= ins_va_i & ins_msk;
        base_q[vic_idx] <= ins_pa_i & ins_msk;
        lsz_q[vic_idx]  <= ins_lsz_i;
        attr_q[vic_idx] <= '{wr: ins_writable_i, usr: ins_user_i,
                             unc: ins_uncache_i, glb: ins_global_i};
      end
      if (do_stamp) begin
        if (seq_q == '1) begin
          // wrap: restart ordering from a clean slate
          for (int i = 0; i < ENTRIES; i++) stamp_q[i] <= '0;
          stamp_q[st_idx] <= SEQ_W'(1);
          seq_q           <= SEQ_W'(2);
        end else begin
          stamp_q[st_idx] <= seq_q;
          seq_q           <= seq_q + SEQ_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SEQ_W   = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lk_valid_i,
  input logic               lk_touch_i,
  input logic               hit_o,
  input logic               miss_o,
  input logic [ADDR_W-1:0]  pa_o,
  input logic               writable_o,
  input logic               user_o,
  input logic               uncache_o,
  input logic               global_o,
  input logic               ins_valid_i,
  input logic               flush_all_i,
  input logic               flush_local_i,
  input logic               demap_valid_i,
  input logic [ENTRIES-1:0] vld_q,
  input logic [ENTRIES-1:0] glb_vec,
  input logic [SEQ_W-1:0]   seq_q
);
  p_hit_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (lk_valid_i && !miss_o));

  p_miss_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (pa_o == '0 && !writable_o && !user_o && !uncache_o && !global_o));

  p_fill_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !flush_all_i && !flush_local_i && !demap_valid_i && !(&vld_q))
    |=> ($countones(vld_q) == $countones($past(vld_q)) + 1));

  p_seq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ins_valid_i || (hit_o && lk_touch_i)) |=> $stable(seq_q));

  p_seq_nz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_q != '0);

  p_flush_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (vld_q == '0));

  p_flush_local_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_local_i && !flush_all_i) |=> ((vld_q & ~$past(glb_vec)) == '0));
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_touch_i(lk_touch_i),
  .hit_o(hit_o), .miss_o(miss_o), .pa_o(pa_o), .writable_o(writable_o),
  .user_o(user_o), .uncache_o(uncache_o), .global_o(global_o),
  .ins_valid_i(ins_valid_i), .flush_all_i(flush_all_i), .flush_local_i(flush_local_i),
  .demap_valid_i(demap_valid_i), .vld_q(vld_q), .glb_vec(glb_vec), .seq_q(seq_q));

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid = 0, lk_touch = 0;
  logic [31:0] lk_va = '0;
  logic        hit_o, miss_o, writable_o, user_o, uncache_o, global_o;
  logic [31:0] pa_o;
  logic        ins_valid = 0;
  logic [31:0] ins_va = '0, ins_pa = '0;
  logic [4:0]  ins_lsz = '0;
  logic [3:0]  ins_at = '0;
  logic        flush_all = 0, flush_local = 0, demap_valid = 0;
  logic [31:0] demap_va = '0;

  int n_chk = 0, n_err = 0;
  logic [31:0] rng = 32'h1234_5678;

  // bench model; attribute order {wr,usr,unc,glb}
  logic        m_vld  [N];
  logic [31:0] m_tag  [N];
  logic [31:0] m_base [N];
  logic [4:0]  m_lsz  [N];
  logic [3:0]  m_at   [N];
  logic [3:0]  m_st   [N];
  logic [3:0]  m_seq;

  always #10 clk = ~clk;

  xlat_cache #(.ENTRIES(N), .ADDR_W(32), .SEQ_W(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid), .lk_va_i(lk_va), .lk_touch_i(lk_touch),
    .hit_o(hit_o), .miss_o(miss_o), .pa_o(pa_o),
    .writable_o(writable_o), .user_o(user_o), .uncache_o(uncache_o), .global_o(global_o),
    .ins_valid_i(ins_valid), .ins_va_i(ins_va), .ins_pa_i(ins_pa), .ins_lsz_i(ins_lsz),
    .ins_writable_i(ins_at[3]), .ins_user_i(ins_at[2]), .ins_uncache_i(ins_at[1]),
    .ins_global_i(ins_at[0]),
    .flush_all_i(flush_all), .flush_local_i(flush_local),
    .demap_valid_i(demap_valid), .demap_va_i(demap_va));

  function automatic logic [31:0] msk(input logic [4:0] l);
    return ~((32'd1 << l) - 32'd1);
  endfunction

  function automatic int m_find(input logic [31:0] va);
    for (int i = 0; i < N; i++)
      if (m_vld[i] && (((va ^ m_tag[i]) & msk(m_lsz[i])) == 0)) return i;
    return -1;
  endfunction

  function automatic logic [31:0] rnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  task automatic m_stamp(input int i);
    if (m_seq == 4'hf) begin
      for (int k = 0; k < N; k++) m_st[k] = 4'd0;
      m_st[i] = 4'd1;
      m_seq   = 4'd2;
    end else begin
      m_st[i] = m_seq;
      m_seq   = m_seq + 4'd1;
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_tag[i] = 0; m_base[i] = 0; m_lsz[i] = 0; m_at[i] = 0; m_st[i] = 0;
    end
    m_seq = 4'd1;
  endtask

  task automatic m_apply(input int lh);
    int v, d;
    if (flush_all) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
    end else if (flush_local) begin
      for (int i = 0; i < N; i++) if (!m_at[i][0]) m_vld[i] = 0;
    end else if (demap_valid) begin
      d = m_find(demap_va);
      if (d >= 0) m_vld[d] = 0;
    end else if (ins_valid) begin
      v = -1;
      for (int i = 0; i < N; i++) if (v < 0 && !m_vld[i]) v = i;
      if (v < 0) begin
        v = 0;
        for (int i = 1; i < N; i++) if (m_st[i] < m_st[v]) v = i;
      end
      m_vld[v] = 1; m_tag[v] = ins_va & msk(ins_lsz); m_base[v] = ins_pa & msk(ins_lsz);
      m_lsz[v] = ins_lsz; m_at[v] = ins_at;
      m_stamp(v);
    end else if (lk_valid && lk_touch && lh >= 0) begin
      m_stamp(lh);
    end
  endtask

  task automatic chk(input logic ok, input string tag, input logic [39:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // inputs were set after a falling edge; check, clock, update model, clear
  task automatic step(input string tag);
    int e;
    logic [39:0] act, exp;
    #2;
    e = m_find(lk_va);
    act = {2'b0, hit_o, miss_o, writable_o, user_o, uncache_o, global_o, pa_o};
    exp = '0;
    if (lk_valid) begin
      if (e >= 0) exp = {2'b0, 2'b10, m_at[e], m_base[e] | (lk_va & ~msk(m_lsz[e]))};
      else        exp = {2'b0, 2'b01, 4'b0, 32'h0};
    end
    chk(act == exp, tag, act, exp);
    @(posedge clk);
    m_apply(e);
    @(negedge clk);
    lk_valid = 0; lk_touch = 0; ins_valid = 0; flush_all = 0; flush_local = 0; demap_valid = 0;
  endtask

  task automatic probe(input logic [31:0] va, input string tag);
    lk_valid = 1; lk_touch = 0; lk_va = va;
    step(tag);
  endtask

  task automatic touch(input logic [31:0] va, input string tag);
    lk_valid = 1; lk_touch = 1; lk_va = va;
    step(tag);
  endtask

  task automatic put(input logic [31:0] va, pa, input logic [4:0] l, input logic [3:0] at);
    ins_valid = 1; ins_va = va; ins_pa = pa; ins_lsz = l; ins_at = at;
  endtask

  task automatic fill4(input logic [31:0] b);
    for (int k = 0; k < 4; k++) begin
      put(b + (k << 12), 32'h9000_0000 + (k << 12), 5'd12, 4'b1100);
      step("R4");
    end
  endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    probe(32'h0000_0000, "R1");
    probe(32'h0040_1000, "R1");

    put(32'h0040_1234, 32'h8000_0abc, 5'd12, 4'b1000); step("R4");
    probe(32'h0040_1fff, "R4");
    probe(32'h0040_1000, "R4");
    probe(32'h0040_2000, "R4");
    put(32'h0123_4567, 32'h4567_89ab, 5'd16, 4'b0110); step("R3");
    probe(32'h0123_ffff, "R3");
    probe(32'h0124_0000, "R3");
    lk_va = 32'h0123_0000; step("R2");

    flush_all = 1; step("R8");
    probe(32'h0040_1fff, "R8");
    probe(32'h0123_0001, "R8");

    fill4(32'h1000_0000);
    touch(32'h1000_0000, "R6");
    put(32'h1000_4000, 32'h9000_4000, 5'd12, 4'b0001); step("R5");
    probe(32'h1000_1000, "R5");
    probe(32'h1000_0000, "R5");
    probe(32'h1000_2000, "R6");
    put(32'h1000_5000, 32'h9000_5000, 5'd12, 4'b0001); step("R6");
    probe(32'h1000_2000, "R6");
    probe(32'h1000_3000, "R6");

    flush_all = 1; step("R8");
    fill4(32'h2000_0000);
    for (int k = 0; k < 20; k++) touch(32'h2000_0000, "R7");
    put(32'h2000_9000, 32'h9000_9000, 5'd12, 4'b0); step("R7");
    probe(32'h2000_1000, "R5");
    probe(32'h2000_2000, "R5");
    probe(32'h2000_0000, "R7");
    probe(32'h2000_9000, "R7");

    flush_all = 1; step("R8");
    put(32'h3000_0000, 32'h5000_0000, 5'd12, 4'b0001); step("R9");
    put(32'h3000_1000, 32'h5000_1000, 5'd12, 4'b1000); step("R9");
    flush_local = 1; step("R9");
    probe(32'h3000_0010, "R9");
    probe(32'h3000_1010, "R9");

    flush_all = 1; step("R8");
    put(32'h0020_0000, 32'h4000_0000, 5'd21, 4'b1000); step("R10");
    put(32'h0021_3000, 32'h7777_7000, 5'd12, 4'b0100); step("R10");
    probe(32'h0021_3abc, "R2");
    demap_valid = 1; demap_va = 32'h0021_3000; step("R10");
    probe(32'h0021_3abc, "R10");
    probe(32'h0020_0000, "R10");
    demap_valid = 1; demap_va = 32'h0500_0000; step("R10");
    probe(32'h0021_3abc, "R10");

    put(32'h0600_0000, 32'h1111_1000, 5'd12, 4'b0); flush_all = 1; step("R11");
    probe(32'h0600_0000, "R11");
    probe(32'h0021_3abc, "R11");
    put(32'h0700_0000, 32'h2222_2000, 5'd12, 4'b0);
    demap_valid = 1; demap_va = 32'h0800_0000; step("R11");
    probe(32'h0700_0000, "R11");

    for (int c = 0; c < 3000; c++) begin
      logic [31:0] r;
      r = rnd();
      lk_valid = (r[1:0] != 0);
      lk_touch = r[2];
      lk_va = {r[4:3], 7'b0, r[5], 4'b0, r[6], 5'b0, r[7], 12'b0} | (rnd() & 32'hfff);
      r = rnd();
      if (r % 100 < 35) begin
        logic [31:0] q;
        q = rnd();
        put({q[1:0], 7'b0, q[2], 4'b0, q[3], 5'b0, q[4], 12'b0}, rnd(),
            (q[6:5] == 0) ? 5'd21 : (q[6:5] == 1) ? 5'd16 : 5'd12,
            {q[9:7], q[12:10] == 0});
      end
      r = rnd();
      demap_valid = (r % 100 < 6);
      demap_va = {r[9:8], 7'b0, r[10], 4'b0, r[11], 5'b0, r[12], 12'b0};
      r = rnd();
      flush_local = (r % 100 < 3);
      flush_all = (r[15:8] < 5);
      step("R3");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule